// File: doc/BRIEF.md
# Gated Transmit Frame Request Arbiter

This block sits between several frame sources and a single frame builder on the transmit side of a serial link. Each source raises a level-held request tagged as either a data frame or a control frame. The arbiter grants one request at a time by fixed priority, with the lowest index winning, and only when the framer reports that it is ready. At the moment of the grant it latches the source index, the frame type and a clear-to-send (CTS) header bit, and it holds them until the framer reports that the frame is complete.

Four configuration bits gate the flow: transmitter enable, arbiter disable, data-frame enable and CTS mode. They are loaded together by a configuration write strobe. Turning the transmitter or the arbiter off is graceful: a frame already granted runs to completion, and only new requests are refused. A refused request gets a one-cycle reject pulse, so its source can withdraw instead of waiting for ever. The CTS bit comes from a hysteresis flag on the free space of the local receive FIFO, which is compared against a high and a low threshold. In push mode the CTS bit is forced to 1. A configuration write with the soft-reset bit set returns every register to its default one cycle later and then clears itself.

Top module: `tx_frame_arbiter`

## Requirements
- R1: Among eligible requests, the lowest index is granted. A grant happens only while the arbiter is idle and `fr_ready` is 1. Eligible requests that are waiting stay pending and are granted later in index order.
- R2: While `cfg_arb_dis` is 1, no new grant is issued and every new request is rejected. A frame granted before the disable stays busy, with its outputs unchanged, until `fr_done`.
- R3: While `cfg_tx_en` is 0, no new grant is issued and every new request is rejected. A frame in progress when the enable is cleared still completes.
- R4: `req_is_data[i]` = 1 marks a data frame and 0 marks a control frame. While `cfg_data_en` is 0, data requests are rejected and control requests are still granted. `fr_is_data` reports the type of the granted frame.
- R5: When `cfg_cts_mode` is 0 (push mode), `fr_cts` is 1 for every granted frame, whatever the FIFO free space.
- R6: The CTS flag becomes 1 when `rx_free >= thr_high` and becomes 0 when `rx_free <= thr_low`. Strictly between the two thresholds it keeps its value. It is 1 after reset. When `cfg_cts_mode` is 1, the flag is copied into `fr_cts` at grant.
- R7: A configuration write with `cfg_soft_rst` = 1 resets the configuration to all zeros, ends any frame in progress, clears pending rejects and sets the CTS flag to 1, one cycle after the write. The soft-reset state then clears itself.
- R8: `grant` is a one-hot pulse lasting one cycle and coincides with `fr_start`. `fr_busy` rises with the grant and falls one cycle after `fr_done`. `fr_src`, `fr_is_data` and `fr_cts` stay stable while busy.
- R9: A request that is not eligible produces a one-cycle pulse on its `reject` bit in the cycle after it is seen. An eligible request that is only waiting is never rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_tx_en | input | 1 | Transmitter enable value to load |
| cfg_arb_dis | input | 1 | Arbiter disable value to load |
| cfg_data_en | input | 1 | Data-frame enable value to load |
| cfg_cts_mode | input | 1 | CTS mode value to load (0 = push mode) |
| cfg_soft_rst | input | 1 | With `cfg_wr`, requests a self-clearing soft reset |
| req_valid | input | N_SRC | Level-held frame requests, bit 0 has highest priority |
| req_is_data | input | N_SRC | Frame type per request (1 = data, 0 = control) |
| rx_free | input | FREE_W | Free entries in the local receive FIFO |
| thr_high | input | FREE_W | Free-space level at or above which CTS is set |
| thr_low | input | FREE_W | Free-space level at or below which CTS is cleared |
| fr_ready | input | 1 | Framer can accept a new frame |
| fr_done | input | 1 | Framer has finished the current frame |
| grant | output | N_SRC | One-hot grant pulse to the winning source |
| reject | output | N_SRC | One-cycle pulse per refused request |
| fr_start | output | 1 | Start pulse to the framer |
| fr_busy | output | 1 | A granted frame is in progress |
| fr_src | output | $clog2(N_SRC) | Index of the source being served |
| fr_is_data | output | 1 | Type of the frame being served |
| fr_cts | output | 1 | CTS header bit of the frame being served |

## Verification
On every cycle, the assertions check the following: the grant is one-hot and matches the start pulse, and a grant always follows a ready framer. No grant is issued while the transmitter or the arbiter is off, and no data frame is granted while data frames are disabled. The push-mode CTS value, the set and clear edges of the hysteresis flag, and the stability of the frame outputs while busy are also checked. Only the directed scenarios can show the ordering of several pending requests, that the flag holds inside the hysteresis band, that a frame in progress outlives a disable, and the complete effect of the soft reset, including the flag returning to 1.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;

    typedef enum logic {
        KIND_CTRL = 1'b0,
        KIND_DATA = 1'b1
    } frame_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic tx_en;
        logic arb_dis;
        logic data_en;
        logic cts_mode;
    } arb_cfg_t;

    localparam arb_cfg_t CFG_DEFAULT = '{tx_en: 1'b0, arb_dis: 1'b0, data_en: 1'b0, cts_mode: 1'b0};

    // Next value of the clear-to-send hysteresis flag; the set condition wins
    // if the thresholds are programmed so that both apply.
    function automatic logic cts_next(input logic cur, input logic at_high, input logic at_low);
        if (at_high)
            return 1'b1;
        else if (at_low)
            return 1'b0;
        else
            return cur;
    endfunction

    // CTS bit placed into a frame header at grant time.
    function automatic logic header_cts(input logic mode, input logic flag);
        return mode ? flag : 1'b1;
    endfunction

endpackage

// File: rtl/tx_arb_ctrl.sv
module tx_arb_ctrl
    import tx_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_wr,
    input  arb_cfg_t cfg_in,
    input  logic     cfg_soft_rst,
    output arb_cfg_t cfg_q,
    output logic     srst_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_DEFAULT;
            srst_q <= 1'b0;
        end else if (srst_q) begin
            cfg_q  <= CFG_DEFAULT;
            srst_q <= 1'b0;
        end else if (cfg_wr) begin
            if (cfg_soft_rst)
                srst_q <= 1'b1;
            else
                cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/tx_arb_cts_hyst.sv
module tx_arb_cts_hyst
    import tx_arb_pkg::*;
#(
    parameter int FREE_W = 8
) (
    input  logic              clk,
    input  logic              clr,
    input  logic [FREE_W-1:0] free_cnt,
    input  logic [FREE_W-1:0] lvl_high,
    input  logic [FREE_W-1:0] lvl_low,
    output logic              flag_q
);

    logic at_high;
    logic at_low;

    always_comb begin
        at_high = (free_cnt >= lvl_high);
        at_low  = (free_cnt <= lvl_low);
    end

    always_ff @(posedge clk) begin
        if (clr)
            flag_q <= 1'b1;
        else
            flag_q <= cts_next(flag_q, at_high, at_low);
    end

endmodule

// File: rtl/tx_arb_pick.sv
module tx_arb_pick #(
    parameter int N_SRC = 4,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             hold,
    input  logic [N_SRC-1:0] req_valid,
    input  logic [N_SRC-1:0] req_is_data,
    input  logic             tx_en,
    input  logic             arb_dis,
    input  logic             data_en,
    output logic             any_elig,
    output logic [IDX_W-1:0] win_idx,
    output logic [N_SRC-1:0] reject_q
);

    logic [N_SRC-1:0] elig;
    logic             gate_open;

    assign gate_open = tx_en && !arb_dis && !hold;

    // Per-source eligibility: global gates plus the data-frame gate.
    for (genvar g = 0; g < N_SRC; g++) begin : g_elig
        assign elig[g] = req_valid[g] && gate_open && (!req_is_data[g] || data_en);
    end

    // Fixed priority: lowest index among eligible sources.
    always_comb begin
        win_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig[i])
                win_idx = IDX_W'(i);
        end
        any_elig = |elig;
    end

    // One-cycle reject pulse for each refused request.
    always_ff @(posedge clk) begin
        if (clr)
            reject_q <= '0;
        else
            reject_q <= req_valid & ~elig & ~reject_q;
    end

endmodule

// File: rtl/tx_frame_arbiter.sv
module tx_frame_arbiter
    import tx_arb_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int FREE_W = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_tx_en,
    input  logic              cfg_arb_dis,
    input  logic              cfg_data_en,
    input  logic              cfg_cts_mode,
    input  logic              cfg_soft_rst,
    input  logic [N_SRC-1:0]  req_valid,
    input  logic [N_SRC-1:0]  req_is_data,
    input  logic [FREE_W-1:0] rx_free,
    input  logic [FREE_W-1:0] thr_high,
    input  logic [FREE_W-1:0] thr_low,
    input  logic              fr_ready,
    input  logic              fr_done,
    output logic [N_SRC-1:0]  grant,
    output logic [N_SRC-1:0]  reject,
    output logic              fr_start,
    output logic              fr_busy,
    output logic [IDX_W-1:0]  fr_src,
    output logic              fr_is_data,
    output logic              fr_cts
);

    arb_cfg_t    cfg_in;
    arb_cfg_t    cfg_q;
    logic        srst_q;
    logic        clr;
    logic        cts_level;
    logic        any_elig;
    logic [IDX_W-1:0] win_idx;

    arb_state_e  state_q;
    logic [IDX_W-1:0] cur_src_q;
    frame_kind_e cur_kind_q;
    logic        cur_cts_q;
    logic [N_SRC-1:0] grant_q;
    logic        start_q;

    assign cfg_in = '{tx_en: cfg_tx_en, arb_dis: cfg_arb_dis,
                      data_en: cfg_data_en, cts_mode: cfg_cts_mode};
    assign clr    = rst || srst_q;

    tx_arb_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cfg_wr       (cfg_wr),
        .cfg_in       (cfg_in),
        .cfg_soft_rst (cfg_soft_rst),
        .cfg_q        (cfg_q),
        .srst_q       (srst_q)
    );

    tx_arb_cts_hyst #(.FREE_W(FREE_W)) u_cts (
        .clk      (clk),
        .clr      (clr),
        .free_cnt (rx_free),
        .lvl_high (thr_high),
        .lvl_low  (thr_low),
        .flag_q   (cts_level)
    );

    tx_arb_pick #(.N_SRC(N_SRC)) u_pick (
        .clk         (clk),
        .clr         (clr),
        .hold        (srst_q),
        .req_valid   (req_valid),
        .req_is_data (req_is_data),
        .tx_en       (cfg_q.tx_en),
        .arb_dis     (cfg_q.arb_dis),
        .data_en     (cfg_q.data_en),
        .any_elig    (any_elig),
        .win_idx     (win_idx),
        .reject_q    (reject)
    );

    // Grant sequencer: idle -> busy at grant, busy -> idle on framer done.
    always_ff @(posedge clk) begin
        if (clr) begin
            state_q    <= ST_IDLE;
            cur_src_q  <= '0;
            cur_kind_q <= KIND_CTRL;
            cur_cts_q  <= 1'b1;
            grant_q    <= '0;
            start_q    <= 1'b0;
        end else begin
            grant_q <= '0;
            start_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (any_elig && fr_ready) begin
                        state_q    <= ST_BUSY;
                        cur_src_q  <= win_idx;
                        cur_kind_q <= req_is_data[win_idx] ? KIND_DATA : KIND_CTRL;
                        cur_cts_q  <= header_cts(cfg_q.cts_mode, cts_level);
                        grant_q    <= N_SRC'(1) << win_idx;
                        start_q    <= 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (fr_done)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign grant      = grant_q;
    assign fr_start   = start_q;
    assign fr_busy    = (state_q == ST_BUSY);
    assign fr_src     = cur_src_q;
    assign fr_is_data = (cur_kind_q == KIND_DATA);
    assign fr_cts     = cur_cts_q;

endmodule

// File: rtl/tx_frame_arbiter_chk.sv
module tx_frame_arbiter_chk
    import tx_arb_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int FREE_W = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              srst,
    input arb_cfg_t          cfg,
    input logic              cts_level,
    input logic [FREE_W-1:0] rx_free,
    input logic [FREE_W-1:0] thr_high,
    input logic [FREE_W-1:0] thr_low,
    input logic              fr_ready,
    input logic [N_SRC-1:0]  grant,
    input logic [N_SRC-1:0]  reject,
    input logic              fr_start,
    input logic              fr_busy,
    input logic [IDX_W-1:0]  fr_src,
    input logic              fr_is_data,
    input logic              fr_cts
);

    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_start_with_grant_R8: assert property (@(posedge clk) disable iff (rst)
        fr_start == (grant != '0));

    assert_frame_held_R8: assert property (@(posedge clk) disable iff (rst)
        (fr_busy && !fr_start) |-> ($stable(fr_src) && $stable(fr_is_data) && $stable(fr_cts)));

    assert_grant_needs_ready_R1: assert property (@(posedge clk) disable iff (rst)
        fr_start |-> $past(fr_ready));

    // Covers R3 as well: no grant while the transmitter is off.
    assert_grant_when_enabled_R2: assert property (@(posedge clk) disable iff (rst)
        fr_start |-> $past(cfg.tx_en && !cfg.arb_dis));

    assert_data_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (fr_start && fr_is_data) |-> $past(cfg.data_en));

    assert_push_cts_R5: assert property (@(posedge clk) disable iff (rst)
        (fr_start && !$past(cfg.cts_mode)) |-> fr_cts);

    assert_cts_set_R6: assert property (@(posedge clk) disable iff (rst)
        (!srst && rx_free >= thr_high) |=> cts_level);

    assert_cts_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (!srst && rx_free <= thr_low && rx_free < thr_high) |=> !cts_level);

    assert_reject_not_granted_R9: assert property (@(posedge clk) disable iff (rst)
        (reject & grant) == '0);

endmodule

bind tx_frame_arbiter tx_frame_arbiter_chk #(.N_SRC(N_SRC), .FREE_W(FREE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .srst       (srst_q),
    .cfg        (cfg_q),
    .cts_level  (cts_level),
    .rx_free    (rx_free),
    .thr_high   (thr_high),
    .thr_low    (thr_low),
    .fr_ready   (fr_ready),
    .grant      (grant),
    .reject     (reject),
    .fr_start   (fr_start),
    .fr_busy    (fr_busy),
    .fr_src     (fr_src),
    .fr_is_data (fr_is_data),
    .fr_cts     (fr_cts)
);

// File: tb/tx_frame_arbiter_tb.sv
module tx_frame_arbiter_tb;

    localparam int N_SRC  = 4;
    localparam int FREE_W = 8;
    localparam int IDX_W  = 2;

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_wr, cfg_tx_en, cfg_arb_dis, cfg_data_en, cfg_cts_mode, cfg_soft_rst;
    logic [N_SRC-1:0]  req_valid, req_is_data;
    logic [FREE_W-1:0] rx_free, thr_high, thr_low;
    logic              fr_ready, fr_done;
    logic [N_SRC-1:0]  grant, reject;
    logic              fr_start, fr_busy, fr_is_data, fr_cts;
    logic [IDX_W-1:0]  fr_src;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tx_frame_arbiter #(.N_SRC(N_SRC), .FREE_W(FREE_W)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_tx_en(cfg_tx_en),
        .cfg_arb_dis(cfg_arb_dis), .cfg_data_en(cfg_data_en),
        .cfg_cts_mode(cfg_cts_mode), .cfg_soft_rst(cfg_soft_rst),
        .req_valid(req_valid), .req_is_data(req_is_data), .rx_free(rx_free),
        .thr_high(thr_high), .thr_low(thr_low), .fr_ready(fr_ready),
        .fr_done(fr_done), .grant(grant), .reject(reject), .fr_start(fr_start),
        .fr_busy(fr_busy), .fr_src(fr_src), .fr_is_data(fr_is_data), .fr_cts(fr_cts)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic tx, input logic dis, input logic dat, input logic mode);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_tx_en = tx; cfg_arb_dis = dis; cfg_data_en = dat; cfg_cts_mode = mode;
        cfg_soft_rst = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic end_frame();
        fr_done = 1'b1;
        @(negedge clk);
        fr_done = 1'b0;
    endtask

    // Full frame from an idle arbiter with a ready framer.
    task automatic run_frame(input int src, input logic dat, input logic exp_cts, input string tag);
        @(negedge clk);
        req_valid[src] = 1'b1; req_is_data[src] = dat;
        @(negedge clk);
        check(tag, "grant", 32'(grant), 32'(1 << src));
        check(tag, "fr_start", 32'(fr_start), 1);
        check(tag, "fr_src", 32'(fr_src), 32'(src));
        check(tag, "fr_is_data", 32'(fr_is_data), 32'(dat));
        check(tag, "fr_cts", 32'(fr_cts), 32'(exp_cts));
        req_valid[src] = 1'b0;
        @(negedge clk);
        check(tag, "busy after grant", 32'(fr_busy), 1);
        check(tag, "start pulse length", 32'(fr_start), 0);
        end_frame();
        check(tag, "busy after done", 32'(fr_busy), 0);
    endtask

    task automatic t_reset();
        check("R8", "grant at reset", 32'(grant), 0);
        check("R9", "reject at reset", 32'(reject), 0);
        check("R8", "busy at reset", 32'(fr_busy), 0);
    endtask

    task automatic t_priority_R1();
        set_cfg(1, 0, 1, 0);
        @(negedge clk);
        req_valid = 4'b1110; req_is_data = 4'b0000;
        @(negedge clk);
        check("R1", "first winner", 32'(grant), 32'h2);
        check("R9", "waiting not rejected", 32'(reject), 0);
        req_valid[1] = 1'b0;
        @(negedge clk);
        end_frame();
        check("R1", "idle after done", 32'(fr_busy), 0);
        @(negedge clk);
        check("R1", "second winner", 32'(grant), 32'h4);
        req_valid[2] = 1'b0;
        end_frame();
        @(negedge clk);
        check("R1", "third winner", 32'(grant), 32'h8);
        req_valid[3] = 1'b0;
        end_frame();
    endtask

    task automatic t_ready_R1();
        fr_ready = 1'b0;
        @(negedge clk);
        req_valid[0] = 1'b1; req_is_data[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", "no grant without ready", 32'(grant | {3'b0, fr_busy}), 0);
        check("R9", "stalled request not rejected", 32'(reject), 0);
        fr_ready = 1'b1;
        @(negedge clk);
        check("R1", "grant once ready", 32'(grant), 32'h1);
        req_valid[0] = 1'b0;
        end_frame();
    endtask

    task automatic t_data_gate_R4();
        set_cfg(1, 0, 0, 0);
        @(negedge clk);
        req_valid = 4'b0101; req_is_data = 4'b0001;
        @(negedge clk);
        check("R4", "control granted past data", 32'(grant), 32'h4);
        check("R9", "data request rejected", 32'(reject), 32'h1);
        @(negedge clk);
        check("R9", "reject is one cycle", 32'(reject), 0);
        req_valid = '0;
        end_frame();
        set_cfg(1, 0, 1, 0);
        run_frame(0, 1'b1, 1'b1, "R4");
    endtask

    task automatic t_gate_midframe(input logic use_dis, input string tag);
        @(negedge clk);
        req_valid[0] = 1'b1; req_is_data[0] = 1'b0;
        @(negedge clk);
        check(tag, "grant before gate", 32'(grant), 32'h1);
        req_valid[0] = 1'b0;
        if (use_dis) set_cfg(1, 1, 1, 0);
        else         set_cfg(0, 0, 1, 0);
        check(tag, "frame kept busy", 32'(fr_busy), 1);
        check(tag, "source held", 32'(fr_src), 0);
        req_valid[1] = 1'b1; req_is_data[1] = 1'b0;
        @(negedge clk);
        check(tag, "new request rejected", 32'(reject), 32'h2);
        end_frame();
        check(tag, "frame completes", 32'(fr_busy), 0);
        @(negedge clk);
        check(tag, "no grant while gated", 32'(grant | {3'b0, fr_busy}), 0);
        req_valid[1] = 1'b0;
        set_cfg(1, 0, 1, 0);
    endtask

    task automatic t_push_R5();
        thr_high = 8'd10; thr_low = 8'd4; rx_free = 8'd0;
        set_cfg(1, 0, 1, 0);
        @(negedge clk);
        run_frame(3, 1'b0, 1'b1, "R5");
    endtask

    task automatic t_hyst_step(input logic [7:0] fr, input logic exp);
        rx_free = fr;
        @(negedge clk);
        @(negedge clk);
        run_frame(2, 1'b0, exp, "R6");
    endtask

    task automatic t_hyst_R6();
        thr_high = 8'd10; thr_low = 8'd4;
        set_cfg(1, 0, 1, 1);
        t_hyst_step(8'd3, 1'b0);
        t_hyst_step(8'd7, 1'b0);
        t_hyst_step(8'd10, 1'b1);
        t_hyst_step(8'd7, 1'b1);
        t_hyst_step(8'd4, 1'b0);
    endtask

    task automatic t_soft_reset_R7();
        thr_high = 8'd10; thr_low = 8'd4; rx_free = 8'd2;
        set_cfg(1, 0, 1, 1);
        @(negedge clk);
        req_valid[0] = 1'b1; req_is_data[0] = 1'b0;
        @(negedge clk);
        check("R7", "frame started", 32'(fr_busy), 1);
        check("R7", "cts low before reset", 32'(fr_cts), 0);
        req_valid[0] = 1'b0;
        rx_free = 8'd7;
        cfg_wr = 1'b1; cfg_soft_rst = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_soft_rst = 1'b0;
        @(negedge clk);
        check("R7", "frame ended by soft reset", 32'(fr_busy), 0);
        req_valid[0] = 1'b1;
        @(negedge clk);
        check("R7", "tx disabled after soft reset", 32'(reject), 32'h1);
        check("R7", "no grant after soft reset", 32'(grant), 0);
        req_valid[0] = 1'b0;
        set_cfg(1, 0, 1, 1);
        run_frame(1, 1'b0, 1'b1, "R7");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R8 watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cfg_wr = 0; cfg_tx_en = 0; cfg_arb_dis = 0; cfg_data_en = 0; cfg_cts_mode = 0; cfg_soft_rst = 0;
        req_valid = '0; req_is_data = '0;
        rx_free = '0; thr_high = 8'd10; thr_low = 8'd4;
        fr_ready = 1'b1; fr_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_priority_R1();
        t_ready_R1();
        t_data_gate_R4();
        t_gate_midframe(1'b1, "R2");
        t_gate_midframe(1'b0, "R3");
        t_push_R5();
        t_hyst_R6();
        t_soft_reset_R7();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule